// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Clear Unit

This block gathers the interrupt events of an I2C controller into twelve latched status bits. Each bit is set by a one-cycle event pulse from the controller and stays set until software clears it. A mask register selects which latched bits may raise the single interrupt line. Software can read both the unmasked status and the masked view.

Clearing is done by register reads. Each source has its own clear address, and reading it clears that bit and nothing else. A separate combined clear address empties every source at once. Because software clears only the bits it has just seen, an event that arrives between the status read and the clear is not lost. A thirteen-bit abort-cause register sits beside the sources and collects the reasons for a transfer abort. Only the dedicated clear read of the abort source wipes it.

Register map (word addresses): 0 raw status, 1 masked status, 2 mask (read/write), 3 abort cause, 4 combined clear, and 8+i the clear address of source i. Read data is registered. It appears on `reg_rdata` one clock after the read strobe.

Top module: `i2c_irq_status_unit`

## Requirements
- R1: After reset the raw status, mask, abort cause, `irq` and `reg_rdata` are all zero.
- R2: A pulse on `evt_pulse[i]` sets raw status bit i, which stays set until cleared. Bit positions are: 0 receive underflow, 1 receive overflow, 2 receive level reached, 3 transmit overflow, 4 transmit level low, 5 read request, 6 transfer abort, 7 receive done, 8 bus activity, 9 stop seen, 10 start seen, 11 general call.
- R3: A read of address 1 returns the raw status ANDed with the mask. A read of address 0 returns the raw status whatever the mask holds.
- R4: A write to address 2 loads the mask from `reg_wdata[11:0]`, and a read of address 2 returns it.
- R5: A read of address 8+i clears raw bit i only. It returns that bit's prior value in bit 0, with all other data bits zero.
- R6: A read of address 4 clears all twelve raw bits. It returns in bit 0 whether any bit was set before the read.
- R7: An event pulse on a source in the same cycle as a clear read that covers it leaves the source set.
- R8: `irq` is the OR of all masked status bits, delayed by one register stage.
- R9: A pulse on `abort_set[j]` sets abort cause bit j, and the bits accumulate. Bits 6 and 8 are reserved and always read zero. The register is read at address 3.
- R10: The abort cause register is cleared only by a read of address 14, the clear address of source 6. The combined clear and the other clear reads leave it unchanged. A cause pulse in the same cycle as the clearing read survives.
- R11: Writes to any address other than 2 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 12 | One-cycle event pulses, one per source |
| abort_set | input | 13 | One-cycle abort cause pulses |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Three latencies matter:
- An event pulse applied before clock edge k sets its raw bit at edge k. The bench therefore reads it back with a read issued after that edge.
- `irq` rises at edge k+1. The bench checks that it is still low just after edge k and high one cycle later.
- Read data and the clear side effect both land on the edge that samples the read strobe. The bench drives every stimulus on the falling edge and samples on the next falling edge, so each value is read half a cycle after the edge that produced it.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
   localparam int DEF_NUM_SRC   = 12;
   localparam int DEF_ABRT_W    = 13;
   localparam int DEF_ADDR_W    = 6;
   localparam int DEF_DATA_W    = 32;
   localparam int DEF_A_RAW     = 0;
   localparam int DEF_A_MASKED  = 1;
   localparam int DEF_A_MASK    = 2;
   localparam int DEF_A_ABORT   = 3;
   localparam int DEF_A_CLR_ALL = 4;
   localparam int DEF_CLR_BASE  = 8;
   localparam int DEF_ABRT_SRC  = 6;
   localparam logic [DEF_ABRT_W-1:0] DEF_ABRT_VALID = 13'h1EBF;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RAW,
      SEL_MASKED,
      SEL_MASK,
      SEL_ABORT,
      SEL_CLR_ALL,
      SEL_CLR_ONE
   } rd_sel_e;
endpackage

// File: rtl/irqu_decode.sv
module irqu_decode
   import irqu_pkg::*;
#(
   parameter int ADDR_W    = DEF_ADDR_W,
   parameter int NUM_SRC   = DEF_NUM_SRC,
   parameter int A_RAW     = DEF_A_RAW,
   parameter int A_MASKED  = DEF_A_MASKED,
   parameter int A_MASK    = DEF_A_MASK,
   parameter int A_ABORT   = DEF_A_ABORT,
   parameter int A_CLR_ALL = DEF_A_CLR_ALL,
   parameter int CLR_BASE  = DEF_CLR_BASE
) (
   input  logic               rd,
   input  logic               wr,
   input  logic [ADDR_W-1:0]  addr,
   output rd_sel_e            sel,
   output logic [NUM_SRC-1:0] clr_one,
   output logic               clr_all,
   output logic               mask_we
);
   logic [NUM_SRC-1:0] hit_one;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr_hit
      assign hit_one[i] = (addr == ADDR_W'(CLR_BASE + i));
   end

   assign clr_one = rd ? hit_one : '0;
   assign clr_all = rd && (addr == ADDR_W'(A_CLR_ALL));
   assign mask_we = wr && (addr == ADDR_W'(A_MASK));

   always_comb begin
      sel = SEL_NONE;
      if (rd) begin
         if (addr == ADDR_W'(A_RAW))          sel = SEL_RAW;
         else if (addr == ADDR_W'(A_MASKED))  sel = SEL_MASKED;
         else if (addr == ADDR_W'(A_MASK))    sel = SEL_MASK;
         else if (addr == ADDR_W'(A_ABORT))   sel = SEL_ABORT;
         else if (addr == ADDR_W'(A_CLR_ALL)) sel = SEL_CLR_ALL;
         else if (|hit_one)                   sel = SEL_CLR_ONE;
      end
   end
endmodule

// File: rtl/irqu_src_bank.sv
module irqu_src_bank #(
   parameter int NUM_SRC = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic [NUM_SRC-1:0] clr_one,
   input  logic               clr_all,
   output logic [NUM_SRC-1:0] raw
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            raw[i] <= 1'b0;
         else if (evt[i])
            raw[i] <= 1'b1;
         else if (clr_one[i] || clr_all)
            raw[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irqu_abort_reg.sv
module irqu_abort_reg #(
   parameter int               ABRT_W = 13,
   parameter logic [ABRT_W-1:0] VALID = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ABRT_W-1:0] set,
   input  logic              clr,
   output logic [ABRT_W-1:0] cause
);
   for (genvar j = 0; j < ABRT_W; j++) begin : g_bit
      if (VALID[j]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cause[j] <= 1'b0;
            else if (set[j])
               cause[j] <= 1'b1;
            else if (clr)
               cause[j] <= 1'b0;
         end
      end else begin : g_rsvd
         assign cause[j] = 1'b0;
      end
   end
endmodule

// File: rtl/irqu_readback.sv
module irqu_readback
   import irqu_pkg::*;
#(
   parameter int NUM_SRC = 12,
   parameter int ABRT_W  = 13,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  rd_sel_e            sel,
   input  logic [NUM_SRC-1:0] raw,
   input  logic [NUM_SRC-1:0] mask,
   input  logic [ABRT_W-1:0]  abort_cause,
   input  logic [NUM_SRC-1:0] clr_one,
   output logic [DATA_W-1:0]  rdata
);
   logic [DATA_W-1:0] nxt;

   always_comb begin
      nxt = '0;
      unique case (sel)
         SEL_RAW:     nxt[NUM_SRC-1:0] = raw;
         SEL_MASKED:  nxt[NUM_SRC-1:0] = raw & mask;
         SEL_MASK:    nxt[NUM_SRC-1:0] = mask;
         SEL_ABORT:   nxt[ABRT_W-1:0]  = abort_cause;
         SEL_CLR_ALL: nxt[0]           = |raw;
         SEL_CLR_ONE: nxt[0]           = |(raw & clr_one);
         default:     nxt              = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (sel != SEL_NONE)
         rdata <= nxt;
   end
endmodule

// File: rtl/i2c_irq_status_unit.sv
module i2c_irq_status_unit
   import irqu_pkg::*;
#(
   parameter int               NUM_SRC   = DEF_NUM_SRC,
   parameter int               ABRT_W    = DEF_ABRT_W,
   parameter int               ADDR_W    = DEF_ADDR_W,
   parameter int               DATA_W    = DEF_DATA_W,
   parameter int               A_RAW     = DEF_A_RAW,
   parameter int               A_MASKED  = DEF_A_MASKED,
   parameter int               A_MASK    = DEF_A_MASK,
   parameter int               A_ABORT   = DEF_A_ABORT,
   parameter int               A_CLR_ALL = DEF_A_CLR_ALL,
   parameter int               CLR_BASE  = DEF_CLR_BASE,
   parameter int               ABRT_SRC  = DEF_ABRT_SRC,
   parameter logic [ABRT_W-1:0] ABRT_VALID = DEF_ABRT_VALID
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_pulse,
   input  logic [ABRT_W-1:0]  abort_set,
   input  logic               reg_rd,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq
);
   localparam int ADDR_SPAN = 1 << ADDR_W;
   localparam int CLR_TOP   = CLR_BASE + NUM_SRC;

   if (NUM_SRC > DATA_W) begin : g_chk_src_w
      $error("NUM_SRC exceeds DATA_W");
   end
   if (ABRT_W > DATA_W) begin : g_chk_abrt_w
      $error("ABRT_W exceeds DATA_W");
   end
   if (CLR_TOP > ADDR_SPAN) begin : g_chk_span
      $error("clear window exceeds address space");
   end
   if (ABRT_SRC >= NUM_SRC) begin : g_chk_abrt_src
      $error("ABRT_SRC out of range");
   end
   if (CLR_BASE <= A_CLR_ALL || CLR_BASE <= A_ABORT) begin : g_chk_overlap
      $error("clear window overlaps fixed registers");
   end

   rd_sel_e            sel;
   logic [NUM_SRC-1:0] clr_one;
   logic               clr_all;
   logic               mask_we;
   logic [NUM_SRC-1:0] raw_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [ABRT_W-1:0]  abort_q;

   irqu_decode #(
      .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .A_RAW(A_RAW), .A_MASKED(A_MASKED),
      .A_MASK(A_MASK), .A_ABORT(A_ABORT), .A_CLR_ALL(A_CLR_ALL), .CLR_BASE(CLR_BASE)
   ) u_decode (
      .rd(reg_rd), .wr(reg_wr), .addr(reg_addr),
      .sel(sel), .clr_one(clr_one), .clr_all(clr_all), .mask_we(mask_we)
   );

   irqu_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk(clk), .rst_n(rst_n), .evt(evt_pulse),
      .clr_one(clr_one), .clr_all(clr_all), .raw(raw_q)
   );

   irqu_abort_reg #(.ABRT_W(ABRT_W), .VALID(ABRT_VALID)) u_abort (
      .clk(clk), .rst_n(rst_n), .set(abort_set),
      .clr(clr_one[ABRT_SRC]), .cause(abort_q)
   );

   irqu_readback #(.NUM_SRC(NUM_SRC), .ABRT_W(ABRT_W), .DATA_W(DATA_W)) u_rb (
      .clk(clk), .rst_n(rst_n), .sel(sel), .raw(raw_q), .mask(mask_q),
      .abort_cause(abort_q), .clr_one(clr_one), .rdata(reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (mask_we)
         mask_q <= reg_wdata[NUM_SRC-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq <= 1'b0;
      else
         irq <= |(raw_q & mask_q);
   end
endmodule

// File: rtl/irqu_checker.sv
module irqu_checker #(
   parameter int               NUM_SRC   = 12,
   parameter int               ABRT_W    = 13,
   parameter int               ADDR_W    = 6,
   parameter int               A_CLR_ALL = 4,
   parameter int               CLR_BASE  = 8,
   parameter int               ABRT_SRC  = 6,
   parameter logic [ABRT_W-1:0] ABRT_VALID = '1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt,
   input logic [ABRT_W-1:0]  abort_set,
   input logic               rd,
   input logic [ADDR_W-1:0]  addr,
   input logic [NUM_SRC-1:0] raw,
   input logic [NUM_SRC-1:0] mask,
   input logic [ABRT_W-1:0]  abort_cause,
   input logic               irq
);
   logic [NUM_SRC-1:0] chk_sel;
   always_comb begin
      chk_sel = '0;
      for (int i = 0; i < NUM_SRC; i++)
         if (rd && (int'(addr) == CLR_BASE + i)) chk_sel[i] = 1'b1;
   end

   assert_single_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|chk_sel) |=> ((raw & $past(chk_sel & ~evt)) == '0));

   assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && int'(addr) == A_CLR_ALL && evt == '0) |=> (raw == '0));

   assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((raw & $past(evt)) == $past(evt)));

   assert_irq_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(|(raw & mask)));

   assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_cause & ~ABRT_VALID) == '0);

   assert_abort_wipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_sel[ABRT_SRC] && abort_set == '0) |=> (abort_cause == '0));
endmodule

bind i2c_irq_status_unit irqu_checker #(
   .NUM_SRC(NUM_SRC), .ABRT_W(ABRT_W), .ADDR_W(ADDR_W), .A_CLR_ALL(A_CLR_ALL),
   .CLR_BASE(CLR_BASE), .ABRT_SRC(ABRT_SRC), .ABRT_VALID(ABRT_VALID)
) u_irqu_checker (
   .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .abort_set(abort_set),
   .rd(reg_rd), .addr(reg_addr), .raw(raw_q), .mask(mask_q),
   .abort_cause(abort_q), .irq(irq)
);

// File: tb/i2c_irq_status_unit_bench.sv
module i2c_irq_status_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] evt_pulse = '0;
   logic [12:0] abort_set = '0;
   logic        reg_rd = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;
   logic [11:0] exp_raw = '0;
   logic [12:0] exp_abort = '0;

   always #4 clk = ~clk;

   i2c_irq_status_unit u_i2c_irq_status_unit (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .abort_set(abort_set),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 6'(a);
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic pulse(input logic [11:0] e, input logic [12:0] ab);
      @(negedge clk);
      evt_pulse = e; abort_set = ab;
      @(negedge clk);
      evt_pulse = '0; abort_set = '0;
      exp_raw |= e;
      exp_abort |= ab & 13'h1EBF;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 irq", 32'(irq), 0);
      check("R1 rdata", reg_rdata, 0);
      rd(0, d); check("R1 raw", d, 0);
      rd(2, d); check("R1 mask", d, 0);
      rd(3, d); check("R1 abort", d, 0);
   endtask

   task automatic t_events();
      logic [31:0] d;
      pulse(12'h001, 0);
      pulse(12'h810, 0);
      rd(0, d); check("R2 raw after pulses", d, 32'(exp_raw));
      pulse(12'h4A4, 0);
      rd(0, d); check("R2 raw second pattern", d, 32'(exp_raw));
      rd(0, d); check("R2 raw sticky", d, 32'(exp_raw));
   endtask

   task automatic t_mask();
      logic [31:0] d;
      wr(2, 32'hFFFF_F0F3);
      rd(2, d); check("R4 mask readback", d, 32'h0000_00F3);
      rd(1, d); check("R3 masked", d, 32'(exp_raw & 12'h0F3));
      rd(0, d); check("R3 raw ignores mask", d, 32'(exp_raw));
   endtask

   task automatic t_clear_one();
      logic [31:0] d;
      rd(8 + 4, d); check("R5 clear return set", d, 1);
      exp_raw[4] = 1'b0;
      rd(0, d); check("R5 only bit4 cleared", d, 32'(exp_raw));
      rd(8 + 4, d); check("R5 clear return clear", d, 0);
      rd(8 + 11, d); check("R5 clear bit11", d, 1);
      exp_raw[11] = 1'b0;
      rd(0, d); check("R5 raw after bit11", d, 32'(exp_raw));
   endtask

   task automatic t_clear_all();
      logic [31:0] d;
      rd(4, d); check("R6 combined return", d, 1);
      exp_raw = '0;
      rd(0, d); check("R6 raw empty", d, 0);
      rd(4, d); check("R6 combined return empty", d, 0);
   endtask

   task automatic t_same_cycle();
      logic [31:0] d;
      pulse(12'h004, 0);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 6'(8 + 2); evt_pulse = 12'h004;
      @(negedge clk);
      reg_rd = 1'b0; evt_pulse = '0;
      rd(0, d); check("R7 per-source clear loses to event", d, 32'(exp_raw));
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 6'd4; evt_pulse = 12'h200;
      @(negedge clk);
      reg_rd = 1'b0; evt_pulse = '0;
      exp_raw = 12'h200;
      rd(0, d); check("R7 combined clear loses to event", d, 32'(exp_raw));
      rd(4, d);
      exp_raw = '0;
   endtask

   task automatic t_irq();
      wr(2, 32'h200);
      pulse(12'h008, 0);
      @(negedge clk);
      check("R8 masked source no irq", 32'(irq), 0);
      @(negedge clk);
      evt_pulse = 12'h200;
      @(negedge clk);
      evt_pulse = '0;
      check("R8 irq not yet", 32'(irq), 0);
      @(negedge clk);
      check("R8 irq one cycle later", 32'(irq), 1);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 6'(8 + 9);
      @(negedge clk);
      reg_rd = 1'b0;
      check("R8 irq holds a cycle", 32'(irq), 1);
      @(negedge clk);
      check("R8 irq drops", 32'(irq), 0);
      exp_raw = 12'h008;
   endtask

   task automatic t_abort();
      logic [31:0] d;
      pulse(0, 13'h1FFF);
      rd(3, d); check("R9 reserved bits zero", d, 32'h1EBF);
      rd(4, d);
      exp_raw = '0;
      rd(3, d); check("R10 combined clear keeps abort", d, 32'(exp_abort));
      rd(8 + 0, d);
      rd(3, d); check("R10 other clear keeps abort", d, 32'(exp_abort));
      rd(8 + 6, d);
      exp_abort = '0;
      rd(3, d); check("R10 abort wiped", d, 0);
      pulse(0, 13'h0001);
      pulse(0, 13'h1000);
      rd(3, d); check("R9 accumulate", d, 32'h1001);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 6'(8 + 6); abort_set = 13'h0008;
      @(negedge clk);
      reg_rd = 1'b0; abort_set = '0;
      rd(3, d); check("R10 same-cycle cause survives", d, 32'h0008);
   endtask

   task automatic t_ignored();
      logic [31:0] d;
      pulse(12'h0A0, 0);
      wr(0, 32'hFFF);
      wr(4, 32'hFFF);
      wr(3, 32'h1FFF);
      wr(8 + 5, 32'hFFF);
      rd(0, d); check("R11 raw untouched by writes", d, 32'(exp_raw));
      rd(3, d); check("R11 abort untouched by writes", d, 32'h0008);
      rd(2, d); check("R11 mask untouched", d, 32'h200);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_events();
      t_mask();
      t_clear_one();
      t_clear_all();
      t_same_cycle();
      t_irq();
      t_abort();
      t_ignored();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule